// File: doc/BRIEF.md
# SCSI Bus Interface Register File

This block is the host-facing register set of a small SCSI bus interface. A host reaches eight byte-wide locations through a 3-bit address with separate read and write strobes. Four locations hold writable state: an output data latch, an initiator command register, a mode register and a target command register. The remaining locations report the live bus lines or start DMA, and one of them clears the interrupt when read.

The block samples the SCSI data lines, a vector of control lines, ACK and ATN. From these it composes a bus-and-status byte, which merges live comparisons with two latched flags: interrupt and end-of-DMA. It tracks a three-state DMA direction (idle, send, initiator receive) and drives a DMA request toward an external data mover. It takes an end-of-transfer pulse back from that mover and drives an interrupt line. Arbitration timing, parity and the movement of data bytes are handled elsewhere.

The control vector has this layout: bit 7 RST, bit 6 BSY, bit 5 REQ, bit 4 MSG, bit 3 C/D, bit 2 I/O, bit 1 SEL, bit 0 bus parity. The mode register has these bits: 0 arbitrate (stored only), 1 DMA enable, 2 monitor busy, 3 end-of-DMA interrupt enable, 7..4 stored only. Initiator command bit 0 asserts the output latch onto the data bus. In the target command register, bits 2..0 hold the expected phase {MSG, C/D, I/O}, bit 3 is stored, and bit 7 is the last-byte-sent flag.

Top module: `scsi_bus_regs`

## Requirements
- R1: A synchronous active-high reset clears every register and flag, returns DMA to idle, and drives dma_req_o and irq_o low. After reset, registers 1, 2 and 3 read 0x00.
- R2: Register 0 reads the output data latch when initiator command bit 0 is set, and the live bus data lines otherwise. A write to address 0 loads the latch.
- R3: Registers 1 and 2 read back the last byte written. Register 3 reads {last-byte-sent, 3'b000, bits 3..0 as written}, so a write cannot set bit 7.
- R4: Register 4 reads the 8-bit control vector unchanged.
- R5: In register 5, bit 3 is 1 when {MSG, C/D, I/O} equals target command bits 2..0. Bit 0 reflects ACK and bit 1 reflects ATN.
- R6: In register 5, bit 6 is REQ AND mode bit 1, and bit 2 is (NOT BSY) AND mode bit 2. Both are live values.
- R7: A write to address 5 starts a send DMA and a write to address 7 starts an initiator-receive DMA. Writes to addresses 4 and 6 change nothing. dma_req_o is high exactly when DMA is not idle, mode bit 1 is set and REQ is high.
- R8: An end-of-transfer pulse during an active DMA latches end-of-DMA (register 5 bit 7) and returns DMA to idle. During a send it also sets last-byte-sent. It raises the interrupt only when mode bit 3 is set.
- R9: A mode write with bit 1 clear clears last-byte-sent and end-of-DMA, and returns DMA to idle.
- R10: The interrupt flag appears on irq_o and in register 5 bit 4. It is set by a falling BSY while mode bit 2 is set, and by a rising REQ while mode bit 1 is set and the phase does not match.
- R11: A read of address 7 clears the interrupt flag.
- R12: Reads of addresses 6 and 7 return 0xFF.
- R13: While BSY is low and mode bit 2 is set, mode bit 1 is cleared and DMA returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect at address 7) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| bus_data_i | input | 8 | Live SCSI data lines |
| bus_ctl_i | input | 8 | Live control lines, layout as above |
| bus_ack_i | input | 1 | Live ACK |
| bus_atn_i | input | 1 | Live ATN |
| xfer_end_i | input | 1 | End-of-transfer pulse from the data mover |
| dma_req_o | output | 1 | DMA request to the data mover |
| irq_o | output | 1 | Interrupt |

## Verification
The status byte is read under several bus patterns:
- a matching phase and a mismatched phase, which isolates the comparison bit;
- REQ with and without the DMA mode bit, which separates live request gating from the DMA state;
- BSY dropping with and without busy monitoring, which shows the difference between a live error bit and a latched interrupt.

DMA is started in both directions and ended by a transfer pulse. This shows that last-byte-sent follows only a send, and that the interrupt follows only the enable bit. Writes to the inert addresses, a mode write that clears DMA, and a busy loss mid-transfer each demonstrate a distinct way the request can fall.

// File: rtl/scsi_bus_regs.sv
module scsi_bus_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] bus_data_i,
  input  logic [7:0]    bus_ctl_i,
  input  logic          bus_ack_i,
  input  logic          bus_atn_i,
  input  logic          xfer_end_i,
  output logic          dma_req_o,
  output logic          irq_o
);
  localparam logic [2:0] A_DATA = 3'd0, A_ICMD = 3'd1, A_MODE = 3'd2, A_TCMD = 3'd3;
  localparam logic [2:0] A_CTL = 3'd4, A_STAT = 3'd5, A_GO_RX = 3'd7;

  typedef enum logic [1:0] {D_IDLE, D_SEND, D_IRECV} dma_t;

  logic [DW-1:0] out_latch, icmd;
  logic [7:0]    mode;
  logic [3:0]    tcmd;
  logic          last_sent, end_flag, int_flag;
  logic          bsy_q, req_q;
  dma_t          dma_st;

  wire bsy = bus_ctl_i[6];
  wire req = bus_ctl_i[5];
  wire phase_ok = (bus_ctl_i[4:2] == tcmd[2:0]);
  wire dma_on = (dma_st != D_IDLE);
  wire busy_lost = !bsy && mode[2];
  wire end_hit = xfer_end_i && dma_on;
  wire rd_clear = reg_rd && (reg_addr == A_GO_RX);

  wire int_set = (end_hit && mode[3])
               | (bsy_q && !bsy && mode[2])
               | (req && !req_q && mode[1] && !phase_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_latch <= '0;
      icmd      <= '0;
      mode      <= '0;
      tcmd      <= '0;
      last_sent <= 1'b0;
      end_flag  <= 1'b0;
      int_flag  <= 1'b0;
      bsy_q     <= 1'b0;
      req_q     <= 1'b0;
      dma_st    <= D_IDLE;
    end else begin
      bsy_q    <= bsy;
      req_q    <= req;
      int_flag <= (int_flag && !rd_clear) || int_set;
      if (end_hit) begin
        end_flag <= 1'b1;
        if (dma_st == D_SEND) last_sent <= 1'b1;
        dma_st <= D_IDLE;
      end
      if (reg_wr) begin
        case (reg_addr)
          A_DATA: out_latch <= reg_wdata;
          A_ICMD: icmd <= reg_wdata;
          A_MODE: begin
            mode <= reg_wdata[7:0];
            if (!reg_wdata[1]) begin
              last_sent <= 1'b0;
              end_flag  <= 1'b0;
              dma_st    <= D_IDLE;
            end
          end
          A_TCMD:  tcmd <= reg_wdata[3:0];
          A_STAT:  dma_st <= D_SEND;
          A_GO_RX: dma_st <= D_IRECV;
          default: ;
        endcase
      end
      if (busy_lost) begin
        mode[1] <= 1'b0;
        dma_st  <= D_IDLE;
      end
    end
  end

  logic [7:0] status;
  assign status = {end_flag, req && mode[1], 1'b0, int_flag,
                   phase_ok, busy_lost, bus_atn_i, bus_ack_i};

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = icmd[0] ? out_latch : bus_data_i;
      A_ICMD:  reg_rdata = icmd;
      A_MODE:  reg_rdata = mode;
      A_TCMD:  reg_rdata = {last_sent, 3'b000, tcmd};
      A_CTL:   reg_rdata = bus_ctl_i;
      A_STAT:  reg_rdata = status;
      default: reg_rdata = '1;
    endcase
  end

  assign dma_req_o = dma_on && mode[1] && req;
  assign irq_o     = int_flag;
endmodule

// File: rtl/scsi_bus_regs_chk.sv
module scsi_bus_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [7:0] bus_ctl_i,
  input logic       xfer_end_i,
  input logic       dma_req_o,
  input logic       irq_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_o && !dma_req_o));

  // R9
  mode_off_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd2 && !reg_wdata[1]) |=> !dma_req_o);

  // R11
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd7 && !xfer_end_i && bus_ctl_i[6] && !bus_ctl_i[5]) |=> !irq_o);

  // R12
  undef_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 3'd6 || reg_addr == 3'd7) |-> reg_rdata == 8'hFF);

  // R8
  end_stops_req_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_end_i && dma_req_o && !(reg_wr && (reg_addr == 3'd5 || reg_addr == 3'd7))) |=> !dma_req_o);

  // R7
  req_needs_bus_req_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |-> bus_ctl_i[5]);
endmodule

bind scsi_bus_regs scsi_bus_regs_chk u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_ctl_i(bus_ctl_i),
  .xfer_end_i(xfer_end_i), .dma_req_o(dma_req_o), .irq_o(irq_o)
);

// File: tb/test_scsi_bus_regs.sv
module test_scsi_bus_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] bus_data_i = '0, bus_ctl_i = 8'h40;
  logic       bus_ack_i = 1'b0, bus_atn_i = 1'b0, xfer_end_i = 1'b0;
  logic       dma_req_o, irq_o;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  scsi_bus_regs i_scsi_bus_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_data_i(bus_data_i),
    .bus_ctl_i(bus_ctl_i), .bus_ack_i(bus_ack_i), .bus_atn_i(bus_atn_i),
    .xfer_end_i(xfer_end_i), .dma_req_o(dma_req_o), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    #5;
    if (reg_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty: got %02h expected none", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          failures++;
          $display("FAIL %s: got %02h expected %02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic set_ctl(input logic [7:0] v);
    @(negedge clk); bus_ctl_i = v;
  endtask

  task automatic pulse_end();
    @(negedge clk); xfer_end_i = 1'b1;
    @(negedge clk); xfer_end_i = 1'b0;
  endtask

  task automatic pins(input logic ed, input logic ei, input string t);
    @(negedge clk); #5;
    checks++;
    if (dma_req_o !== ed || irq_o !== ei) begin
      failures++;
      $display("FAIL %s: got dma=%b irq=%b expected dma=%b irq=%b", t, dma_req_o, irq_o, ed, ei);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    pins(1'b0, 1'b0, "R1 pins after reset");
    rd(3'd1, 8'h00, "R1 icmd");
    rd(3'd2, 8'h00, "R1 mode");
    rd(3'd3, 8'h00, "R1 tcmd");
    rd(3'd5, 8'h08, "R1 R5 status idle");
    // R2 data path
    bus_data_i = 8'h5A;
    rd(3'd0, 8'h5A, "R2 live data");
    wr(3'd0, 8'hC3);
    rd(3'd0, 8'h5A, "R2 latch hidden");
    wr(3'd1, 8'h01);
    rd(3'd0, 8'hC3, "R2 latch asserted");
    rd(3'd1, 8'h01, "R3 icmd readback");
    // R3
    wr(3'd2, 8'hF0);
    rd(3'd2, 8'hF0, "R3 mode readback");
    wr(3'd3, 8'hFA);
    rd(3'd3, 8'h0A, "R3 tcmd bit7 not writable");
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    // R4
    set_ctl(8'hA5);
    rd(3'd4, 8'hA5, "R4 control lines");
    set_ctl(8'h40);
    // R5 phase compare, ACK
    wr(3'd3, 8'h05);
    set_ctl(8'h54); bus_ack_i = 1'b1;
    rd(3'd5, 8'h09, "R5 phase match with ack");
    set_ctl(8'h50);
    rd(3'd5, 8'h01, "R5 phase mismatch");
    bus_ack_i = 1'b0; bus_atn_i = 1'b1;
    rd(3'd5, 8'h02, "R5 atn bit");
    bus_atn_i = 1'b0;
    wr(3'd3, 8'h00);
    set_ctl(8'h60);
    // R6 request gating
    rd(3'd5, 8'h08, "R6 req without dma bit");
    wr(3'd2, 8'h02);
    rd(3'd5, 8'h48, "R6 req with dma bit");
    pins(1'b0, 1'b0, "R7 no request while idle");
    // R6 busy error, R10 busy fall interrupt, R11, R12
    wr(3'd2, 8'h04);
    set_ctl(8'h00);
    rd(3'd5, 8'h1C, "R6 R10 busy error and interrupt");
    pins(1'b0, 1'b1, "R10 irq on busy fall");
    rd(3'd7, 8'hFF, "R12 addr7 read");
    rd(3'd5, 8'h0C, "R11 interrupt cleared");
    rd(3'd6, 8'hFF, "R12 addr6 read");
    set_ctl(8'h40);
    wr(3'd2, 8'h00);
    // R7 send start
    wr(3'd2, 8'h02);
    set_ctl(8'h60);
    wr(3'd5, 8'h00);
    pins(1'b1, 1'b0, "R7 send request");
    set_ctl(8'h40);
    pins(1'b0, 1'b0, "R7 request follows REQ low");
    set_ctl(8'h60);
    pins(1'b1, 1'b0, "R7 request follows REQ high");
    // R8 end of send with interrupt enabled
    wr(3'd2, 8'h0A);
    pulse_end();
    pins(1'b0, 1'b1, "R8 end of send");
    rd(3'd5, 8'hD8, "R8 end flag latched");
    rd(3'd3, 8'h80, "R8 last byte sent");
    rd(3'd7, 8'hFF, "R11 clear read");
    pins(1'b0, 1'b0, "R11 irq cleared");
    // R9 mode clear
    wr(3'd2, 8'h08);
    rd(3'd3, 8'h00, "R9 last byte cleared");
    rd(3'd5, 8'h08, "R9 end flag cleared");
    // R7 inert addresses and receive
    wr(3'd2, 8'h02);
    wr(3'd6, 8'h55);
    pins(1'b0, 1'b0, "R7 addr6 write inert");
    wr(3'd4, 8'hAA);
    pins(1'b0, 1'b0, "R7 addr4 write inert");
    rd(3'd1, 8'h01, "R7 icmd untouched");
    rd(3'd2, 8'h02, "R7 mode untouched");
    wr(3'd7, 8'h00);
    pins(1'b1, 1'b0, "R7 receive request");
    pulse_end();
    pins(1'b0, 1'b0, "R8 end of receive no irq");
    rd(3'd5, 8'hC8, "R8 receive end flag");
    rd(3'd3, 8'h00, "R8 no last byte on receive");
    // R10 phase mismatch on REQ rise
    set_ctl(8'h40);
    wr(3'd3, 8'h01);
    set_ctl(8'h60);
    pins(1'b0, 1'b1, "R10 mismatch interrupt");
    rd(3'd7, 8'hFF, "R11 clear read 2");
    pins(1'b0, 1'b0, "R11 irq cleared 2");
    wr(3'd3, 8'h00);
    // R13 busy loss abort
    wr(3'd2, 8'h06);
    wr(3'd5, 8'h00);
    pins(1'b1, 1'b0, "R13 active before loss");
    set_ctl(8'h20);
    pins(1'b0, 1'b1, "R13 abort on busy loss");
    rd(3'd2, 8'h04, "R13 dma bit cleared");
    set_ctl(8'h40);
    rd(3'd7, 8'hFF, "R11 clear read 3");
    // R1 reset mid-run
    wr(3'd2, 8'h0F);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(3'd2, 8'h00, "R1 mode after second reset");
    rd(3'd1, 8'h00, "R1 icmd after second reset");
    pins(1'b0, 1'b0, "R1 pins after second reset");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule